// File: doc/BRIEF.md
# Read Burst Deserializer with Fixed-Latency Valid

This block takes one system-clock word per cycle holding a double-rate read burst already captured from every data lane. It rebuilds that burst into the per-phase read words a memory controller expects. Every lane delivers `BEATS` beats per system cycle. Beats are paired into `BEATS/2` phases, and each phase word is `2*LANES` bits wide. The data path never stops: it reassembles whatever the lanes carry on every cycle, whether or not a read is pending. The controller therefore qualifies the data only through the valid flag.

The valid flag follows its own path. A read-enable seen on any phase in one cycle is carried through a shift register of depth `RD_LAT`. It comes out as a one-cycle valid on all phases together. Several reads can be in flight at once, and reads on consecutive cycles give valids on consecutive cycles. A static `SLIP` parameter shifts the beat window by a fixed number of beats to absorb a misaligned burst. A register stage is always kept in the data path so that a non-zero slip costs no extra latency.

Top module: `dq_read_deser`

## Requirements
- R1: Input bit `burst_in[i*BEATS + b]` is beat b of lane i. After realignment, beat 2k of lane i appears at `rd_data[k*2*LANES + i]` and beat 2k+1 appears at `rd_data[k*2*LANES + LANES + i]`. Phase k occupies bits `[k*2*LANES +: 2*LANES]`.
- R2: With `SLIP` = 0, a word presented in cycle c appears fully mapped on `rd_data` in cycle c + `DES_DELAY`. `DES_DELAY` is 3 by default and at least 2.
- R3: The data path converts and delivers data every cycle, including cycles in which no read is outstanding and `rd_en` is all zero.
- R4: If any bit of `rd_en` is high in cycle c, `rd_valid` is all ones in cycle c + `RD_LAT`. `RD_LAT` is 9 by default. No valid appears earlier than `RD_LAT` cycles after reset.
- R5: Each cycle with a read-enable produces exactly one valid cycle. Enables in consecutive cycles produce valids in consecutive cycles, and up to `RD_LAT` reads can be outstanding at once.
- R6: Several `rd_en` bits high in one cycle count as one read and give a single valid cycle. `rd_valid` is always either all zeros or all ones.
- R7: While `rst_n` is low, `rd_data` and `rd_valid` are zero, and any read in flight is dropped.
- R8: With `SLIP` = s, beat j of lane i in the output window is taken from position s + j of the lane's beat stream. Positions below `BEATS` come from the earlier word and the rest from the following word. The result appears in cycle c + `DES_DELAY`, where c is the cycle of the earlier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_in | input | LANES*BEATS | Captured beats of all lanes for one system cycle |
| rd_en | input | BEATS/2 | Per-phase read enable from the controller |
| rd_data | output | (BEATS/2)*2*LANES | Reassembled per-phase read data |
| rd_valid | output | BEATS/2 | Read-data valid, identical on all phases |

## Verification
Two results are due at different times. Mapped data is due `DES_DELAY` cycles after the word that holds its first beat. The valid pulse is due exactly `RD_LAT` cycles after the read-enable. The bench keeps a history of every word and enable it drives. Each cycle, away from the clock edge, it compares the outputs with the entries `DES_DELAY`, `DES_DELAY`-1 and `RD_LAT` cycles back, so a result that arrives one cycle early or late fails on both neighbouring cycles. A second instance with a non-zero slip shows that the window spanning two words meets the same deadline.

// File: rtl/dqrd_pkg.sv
package dqrd_pkg;

   // flat position of beat b on lane l in a lane-major burst word
   function automatic int unsigned lane_pos(int unsigned l, int unsigned b, int unsigned beats);
      return l * beats + b;
   endfunction

   // flat position of a bit inside the phase-major output word
   function automatic int unsigned phase_pos(int unsigned k, int unsigned half, int unsigned l,
                                             int unsigned lanes);
      return k * 2 * lanes + half * lanes + l;
   endfunction

endpackage

// File: rtl/dqrd_slip_align.sv
module dqrd_slip_align #(
   parameter int unsigned LANES = 16,
   parameter int unsigned BEATS = 16,
   parameter int unsigned SLIP  = 0,
   localparam int unsigned WORD_W = LANES * BEATS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] window_out
);
   import dqrd_pkg::*;

   logic [WORD_W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= word_in;
   end

   if (SLIP == 0) begin : g_aligned
      assign window_out = prev_q;
   end else begin : g_slipped
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [2*BEATS-1:0] pair;
         assign pair = {word_in[lane_pos(l, 0, BEATS) +: BEATS],
                        prev_q[lane_pos(l, 0, BEATS) +: BEATS]};
         assign window_out[lane_pos(l, 0, BEATS) +: BEATS] = pair[SLIP +: BEATS];
      end
   end

endmodule

// File: rtl/dqrd_lane_map.sv
module dqrd_lane_map #(
   parameter int unsigned LANES = 16,
   parameter int unsigned BEATS = 16,
   localparam int unsigned PHASES = BEATS / 2,
   localparam int unsigned WORD_W = LANES * BEATS
) (
   input  logic [WORD_W-1:0] window_in,
   output logic [WORD_W-1:0] phase_out
);
   import dqrd_pkg::*;

   for (genvar k = 0; k < PHASES; k++) begin : g_phase
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign phase_out[phase_pos(k, 0, l, LANES)] = window_in[lane_pos(l, 2*k, BEATS)];
         assign phase_out[phase_pos(k, 1, l, LANES)] = window_in[lane_pos(l, 2*k+1, BEATS)];
      end
   end

   // R1: the reordering neither drops nor duplicates a bit
   always_comb begin
      if (!$isunknown(window_in)) begin
         p_bits_kept_r1: assert ($countones(phase_out) == $countones(window_in));
      end
   end

endmodule

// File: rtl/dqrd_delay_line.sv
module dqrd_delay_line #(
   parameter int unsigned WIDTH  = 256,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 1) begin : g_chk_stages
      $error("dqrd_delay_line needs at least one stage");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dqrd_valid_timer.sv
module dqrd_valid_timer #(
   parameter int unsigned PHASES = 8,
   parameter int unsigned RD_LAT = 9,
   localparam int unsigned CW = $clog2(RD_LAT + 1) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PHASES-1:0] rd_en,
   output logic [PHASES-1:0] rd_valid
);
   logic          req_any;
   logic [RD_LAT-1:0] pipe_q;
   logic          due;

   assign req_any = |rd_en;

   if (RD_LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= req_any;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[RD_LAT-2:0], req_any};
      end
   end

   assign due      = pipe_q[RD_LAT-1];
   assign rd_valid = {PHASES{due}};

   // checker state: reads outstanding and cycles since reset
   logic [CW-1:0] inflight_q;
   logic [CW-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight_q <= '0;
         age_q      <= '0;
      end else begin
         if (req_any && !rd_valid[0])      inflight_q <= inflight_q + 1'b1;
         else if (!req_any && rd_valid[0]) inflight_q <= inflight_q - 1'b1;
         if (age_q < CW'(RD_LAT))          age_q <= age_q + 1'b1;
      end
   end

   p_inflight_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      inflight_q <= CW'(RD_LAT));

   p_valid_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[0] |-> (inflight_q != '0));

   p_no_early_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q < CW'(RD_LAT)) |-> (rd_valid == '0));

   p_valid_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(rd_valid) == 0) || ($countones(rd_valid) == PHASES));

endmodule

// File: rtl/dq_read_deser.sv
module dq_read_deser #(
   parameter int unsigned LANES     = 16,
   parameter int unsigned BEATS     = 16,
   parameter int unsigned DES_DELAY = 3,
   parameter int unsigned RD_LAT    = 9,
   parameter int unsigned SLIP      = 0,
   localparam int unsigned PHASES = BEATS / 2,
   localparam int unsigned WORD_W = LANES * BEATS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] burst_in,
   input  logic [PHASES-1:0] rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic [PHASES-1:0] rd_valid
);
   if (BEATS < 2 || (BEATS % 2) != 0) begin : g_chk_beats
      $error("BEATS must be an even number of at least 2");
   end
   if (SLIP >= BEATS) begin : g_chk_slip
      $error("SLIP must be below BEATS");
   end
   if (DES_DELAY < 2) begin : g_chk_delay
      $error("DES_DELAY must be at least 2");
   end
   if (RD_LAT < 1) begin : g_chk_lat
      $error("RD_LAT must be at least 1");
   end

   logic [WORD_W-1:0] window;
   logic [WORD_W-1:0] mapped;

   dqrd_slip_align #(.LANES(LANES), .BEATS(BEATS), .SLIP(SLIP)) u_align (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_in    (burst_in),
      .window_out (window)
   );

   dqrd_lane_map #(.LANES(LANES), .BEATS(BEATS)) u_map (
      .window_in (window),
      .phase_out (mapped)
   );

   dqrd_delay_line #(.WIDTH(WORD_W), .STAGES(DES_DELAY - 1)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mapped),
      .q     (rd_data)
   );

   dqrd_valid_timer #(.PHASES(PHASES), .RD_LAT(RD_LAT)) u_valid (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_valid (rd_valid)
   );

   // R7: nothing leaves the block in the cycle right after reset is released
   p_quiet_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_valid == '0));

endmodule

// File: tb/dq_read_deser_tb_top.sv
`timescale 1ns/1ps
module dq_read_deser_tb_top;
   localparam int L = 4;
   localparam int B = 8;
   localparam int P = B / 2;
   localparam int W = L * B;
   localparam int DD = 3;
   localparam int RL = 9;
   localparam int SL = 3;
   localparam int HN = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] burst_in = '0;
   logic [P-1:0] rd_en = '0;
   logic [W-1:0] data_a, data_s;
   logic [P-1:0] val_a, val_s;

   always #5 clk = ~clk;

   dq_read_deser #(.LANES(L), .BEATS(B), .DES_DELAY(DD), .RD_LAT(RL), .SLIP(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .burst_in(burst_in), .rd_en(rd_en),
      .rd_data(data_a), .rd_valid(val_a));

   dq_read_deser #(.LANES(L), .BEATS(B), .DES_DELAY(DD), .RD_LAT(RL), .SLIP(SL)) dut_slip_i (
      .clk(clk), .rst_n(rst_n), .burst_in(burst_in), .rd_en(rd_en),
      .rd_data(data_s), .rd_valid(val_s));

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;
   logic [W-1:0] word_h [HN];
   logic         en_h   [HN];

   function automatic logic [W-1:0] wh(int idx);
      return (idx < 0) ? '0 : word_h[idx];
   endfunction

   function automatic logic eh(int idx);
      return (idx < 0) ? 1'b0 : en_h[idx];
   endfunction

   // expected output for earlier word p, following word c and slip s
   function automatic logic [W-1:0] expect_data(logic [W-1:0] p, logic [W-1:0] c, int s);
      logic [W-1:0] win, r;
      for (int i = 0; i < L; i++) begin
         for (int j = 0; j < B; j++) begin
            int idx = s + j;
            win[i*B + j] = (idx < B) ? p[i*B + idx] : c[i*B + idx - B];
         end
      end
      for (int k = 0; k < P; k++) begin
         for (int i = 0; i < L; i++) begin
            r[k*2*L + i]     = win[i*B + 2*k];
            r[k*2*L + L + i] = win[i*B + 2*k + 1];
         end
      end
      return r;
   endfunction

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
      end
   endtask

   task automatic step(logic [W-1:0] w, logic [P-1:0] en, string dtag, string vtag);
      @(negedge clk);
      chk(dtag, data_a, expect_data(wh(cyc - DD), wh(cyc - DD + 1), 0));
      chk("R8 slipped window", data_s, expect_data(wh(cyc - DD), wh(cyc - DD + 1), SL));
      chk(vtag, W'(val_a), eh(cyc - RL) ? W'({P{1'b1}}) : '0);
      chk(vtag, W'(val_s), eh(cyc - RL) ? W'({P{1'b1}}) : '0);
      burst_in = w;
      rd_en = en;
      word_h[cyc] = w;
      en_h[cyc] = |en;
      cyc++;
   endtask

   task automatic do_reset();
      rst_n = 0;
      burst_in = '0;
      rd_en = '0;
      for (int i = 0; i < HN; i++) begin
         word_h[i] = '0;
         en_h[i] = 1'b0;
      end
      cyc = 0;
      for (int n = 0; n < 3; n++) begin
         @(negedge clk);
         chk("R7 data in reset", data_a, '0);
         chk("R7 data in reset", data_s, '0);
         chk("R7 valid in reset", W'(val_a), '0);
         chk("R7 valid in reset", W'(val_s), '0);
      end
      @(negedge clk);
      rst_n = 1;
   endtask

   function automatic logic [W-1:0] hashw(int n);
      return W'(n * 32'h9E3779B1) ^ W'(n << 7) ^ 32'h5A3C_0F96;
   endfunction

   initial begin
      do_reset();
      // walking one over every input bit, no reads pending
      for (int b = 0; b < W; b++) step(W'(1) << b, '0, "R1 walking bit", "R3 idle valid");
      // dense patterns
      step('1, '0, "R1 all ones", "R3 idle valid");
      step(32'hAAAA_AAAA, '0, "R1 odd beats", "R3 idle valid");
      step(32'h5555_5555, '0, "R1 even beats", "R3 idle valid");
      step(32'h0F0F_0F0F, '0, "R2 nibble pattern", "R3 idle valid");
      for (int n = 0; n < 16; n++) step(hashw(n), '0, "R3 data without read", "R3 idle valid");
      // single read on each phase bit in turn
      for (int k = 0; k < P; k++) begin
         step(hashw(100 + k), P'(1) << k, "R2 data during read", "R4 single read");
         for (int g = 0; g < 11; g++) step(hashw(200 + 16*k + g), '0, "R2 data", "R4 single read");
      end
      // back-to-back reads
      for (int n = 0; n < 3; n++) step(hashw(300 + n), 4'b0001, "R2 data", "R5 back to back");
      for (int n = 0; n < 12; n++) step(hashw(310 + n), '0, "R2 data", "R5 back to back");
      // several enables in one cycle
      step(hashw(330), 4'b1011, "R2 data", "R6 multi phase enable");
      for (int n = 0; n < 11; n++) step(hashw(331 + n), '0, "R2 data", "R6 multi phase enable");
      // reads every other cycle, many in flight
      for (int n = 0; n < 10; n++) step(hashw(350 + n), (n % 2 == 0) ? 4'b0100 : 4'b0000,
                                        "R2 data", "R5 overlapping reads");
      for (int n = 0; n < 12; n++) step(hashw(370 + n), '0, "R2 data", "R5 overlapping reads");
      // reset while a read is in flight drops it
      step(hashw(400), 4'b1000, "R2 data", "R4 before reset");
      for (int n = 0; n < 5; n++) step(hashw(401 + n), '0, "R2 data", "R4 before reset");
      do_reset();
      for (int n = 0; n < 12; n++) step(hashw(420 + n), '0, "R7 data after reset", "R7 dropped read");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired at cycle %0d actual=hung expected=finished", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule